// File: doc/BRIEF.md
# Serial Test Pattern Generator with Zero-Run Suppression

This block produces the transmit bit stream of a bit error rate tester, one bit per clock. In repeat mode it plays a programmable 1-to-32-bit word over and over, most significant bit first. In pseudorandom mode it runs a Fibonacci shift-register sequence. The sequence length and its feedback taps are given at the inputs, and it is seeded from the same word. A new word or seed is taken on a rising edge of a load request. That request is the OR of a control bit and a separate pin, and it passes through a two-flop synchronizer first.

An optional suppression stage looks ahead over the next 14 generated bits. When all of them are zero, it forces the bit now being transmitted to one. This caps any zero run on the line at 14 bits, which is the usual companion of the x^20 + x^17 + 1 quasi-random sequence. The generator itself runs on unaltered; only the transmitted copy is changed. Because of the lookahead window, the stream reaches the output 19 clocks after the load request rises.

Top module: `bert_txgen`

## Requirements
- R1: After reset, with no load performed and suppression disabled, `tx_data` is 0 on every clock.
- R2: When `load_reg | load_pin` rises, the first bit of the new stream is on `tx_data` after the 19th rising clock edge, counting the first edge that samples the high request as edge 1. Each later bit follows on each following edge.
- R3: A load request held high loads only once. Changing `pat_set` while the request stays high does not change the stream.
- R4: Either source alone triggers a load. Raising `load_reg` while `load_pin` is already high triggers no load.
- R5: With `mode`=0 and `len_m1`=L-1, the stream is `pat_set[L-1]`, `pat_set[L-2]`, ... `pat_set[0]`, repeating with period L and no gap, for every L from 1 to 32.
- R6: With `mode`=1, let m be the mask of the low L bits. The state starts at `pat_set & m`. The output bit is state bit L-1. The next state is the state shifted up by one, with new bit 0 equal to the XOR of `state & taps & m`. The polynomial x^20+x^17+1 is given with `len_m1`=19 and `taps`=0x00090000.
- R7: In pseudorandom mode, a seed whose low L bits are all zero is replaced by all ones in those L bits.
- R8: With `zs_en`=1, the transmitted bit for generator bit k is `g[k] | (g[k+1..k+14] all 0)`. This holds in both modes, so no zero run on `tx_data` exceeds 14 bits.
- R9: With `zs_en`=0, `tx_data` equals the generator stream unaltered. A 19-zero run of the sequence appears in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_set | input | 32 | Repeat word or pseudorandom seed |
| len_m1 | input | 5 | Word length / register length minus one |
| taps | input | 32 | Feedback tap mask for pseudorandom mode |
| mode | input | 1 | 0 = repeat word, 1 = pseudorandom |
| zs_en | input | 1 | 1 enables zero-run suppression |
| load_reg | input | 1 | Load request, control-bit source |
| load_pin | input | 1 | Load request, pin source |
| tx_data | output | 1 | Registered transmit bit |

## Verification
The repeat mode is swept over every length from 1 to 32, with the load source alternating between pin and control bit. This separates length wrap, bit order and the 19-clock latency. The pseudorandom mode is tried with three different register lengths and tap sets, with a seed masked to zero, and with a seed that places a 19-zero run right at the start. Suppression is tried on and off on that same run and on a single-one repeat word, which tells the lookahead rule apart from plain pass-through. Held requests are checked with a changed word and with a second source rising late, to show that no second load occurs.

// File: rtl/bert_txgen_pkg.sv
package bert_txgen_pkg;
  typedef enum logic {
    MODE_REPEAT = 1'b0,
    MODE_PRBS   = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/txgen_load_edge.sv
module txgen_load_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_reg,
  input  logic req_pin,
  output logic load_pulse
);
  logic req_any;
  logic sync_a, sync_b, hist;

  assign req_any = req_reg | req_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      hist   <= 1'b0;
    end else begin
      sync_a <= req_any;
      sync_b <= sync_a;
      hist   <= sync_b;
    end
  end

  assign load_pulse = sync_b & ~hist;

  AST_LOAD_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> $past(req_any, 2)); // R2

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> (!load_pulse || !$past(req_any, 2))); // R3
endmodule

// File: rtl/txgen_engine.sv
module txgen_engine
  import bert_txgen_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 mode,
  input  logic [$clog2(W)-1:0] len_m1,
  input  logic [W-1:0]         taps,
  input  logic [W-1:0]         seed,
  output logic                 gen_bit
);
  localparam int LW = $clog2(W);

  logic [W-1:0]  pat;
  logic [LW-1:0] idx;
  logic [W-1:0]  lfsr;
  logic [W-1:0]  mask;
  logic [W-1:0]  seed_m;
  logic          fb;
  logic          rep_out;
  logic          prbs_out;

  assign mask   = {W{1'b1}} >> (W - 1 - int'(len_m1));
  assign seed_m = seed & mask;
  assign fb     = ^(lfsr & taps & mask);

  // repeating word path
  always_ff @(posedge clk) begin
    if (rst) begin
      pat <= '0;
      idx <= '0;
    end else if (load) begin
      pat <= seed;
      idx <= '0;
    end else if (idx >= len_m1) begin
      idx <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  assign rep_out = pat[len_m1 - idx];

  // shift register sequence path
  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= '0;
    end else if (load) begin
      lfsr <= (seed_m == '0) ? mask : seed_m;
    end else begin
      lfsr <= {lfsr[W-2:0], fb};
    end
  end

  assign prbs_out = lfsr[len_m1];

  always_comb begin
    if (gen_mode_e'(mode) == MODE_PRBS) gen_bit = prbs_out;
    else                                gen_bit = rep_out;
  end

  AST_REP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (idx > len_m1) |=> (idx == '0)); // R5

  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> ((lfsr & $past(mask)) != '0)); // R7
endmodule

// File: rtl/txgen_zsup.sv
module txgen_zsup #(
  parameter int LA = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic gen_bit,
  input  logic zs_en,
  output logic tx
);
  localparam int CW = $clog2(LA + 2);

  logic [LA:0] line;
  logic        ahead_zero;

  assign ahead_zero = ~|line[LA-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
      tx   <= 1'b0;
    end else begin
      line <= {line[LA-1:0], gen_bit};
      tx   <= line[LA] | (zs_en & ahead_zero);
    end
  end

  // zero run length seen on the output while suppression stays on
  logic          zs_q;
  logic [CW-1:0] zrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      zs_q <= 1'b0;
      zrun <= '0;
    end else begin
      zs_q <= zs_en;
      if (!zs_en || !zs_q || tx) zrun <= '0;
      else if (zrun != CW'(LA + 1)) zrun <= zrun + 1'b1;
    end
  end

  AST_ZS_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    zrun <= CW'(LA)); // R8

  AST_ZS_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(zs_en) |-> (tx == $past(line[LA]))); // R9
endmodule

// File: rtl/bert_txgen.sv
module bert_txgen #(
  parameter int W  = 32,
  parameter int LA = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         pat_set,
  input  logic [$clog2(W)-1:0] len_m1,
  input  logic [W-1:0]         taps,
  input  logic                 mode,
  input  logic                 zs_en,
  input  logic                 load_reg,
  input  logic                 load_pin,
  output logic                 tx_data
);
  logic load_pulse;
  logic gen_bit;

  txgen_load_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .req_reg    (load_reg),
    .req_pin    (load_pin),
    .load_pulse (load_pulse)
  );

  txgen_engine #(.W(W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .load    (load_pulse),
    .mode    (mode),
    .len_m1  (len_m1),
    .taps    (taps),
    .seed    (pat_set),
    .gen_bit (gen_bit)
  );

  txgen_zsup #(.LA(LA)) u_zsup (
    .clk     (clk),
    .rst     (rst),
    .gen_bit (gen_bit),
    .zs_en   (zs_en),
    .tx      (tx_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !tx_data); // R1
endmodule

// File: tb/bert_txgen_test.sv
module bert_txgen_test;
  localparam int NMAX = 700;
  localparam int LAT  = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pat_set = '0;
  logic [4:0]  len_m1 = '0;
  logic [31:0] taps = '0;
  logic        mode = 1'b0;
  logic        zs_en = 1'b0;
  logic        load_reg = 1'b0;
  logic        load_pin = 1'b0;
  logic        tx_data;

  int checks = 0;
  int errors = 0;
  bit gbits [0:NMAX+15];
  bit ebits [0:NMAX];

  always #10 clk = ~clk;

  bert_txgen uut (
    .clk(clk), .rst(rst), .pat_set(pat_set), .len_m1(len_m1), .taps(taps),
    .mode(mode), .zs_en(zs_en), .load_reg(load_reg), .load_pin(load_pin),
    .tx_data(tx_data)
  );

  task automatic chk(input bit act, input bit exp, input string tag, input int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bit %0d actual %0b expected %0b", tag, idx, act, exp);
    end
  endtask

  // expected stream from the requirements
  task automatic build(input bit md, input int lm1, input logic [31:0] tp,
                       input logic [31:0] sv, input bit zs, input int n);
    logic [31:0] m, s;
    bit allz;
    m = 32'hFFFF_FFFF >> (31 - lm1);
    s = sv & m;
    if (s == 0) s = m;
    for (int i = 0; i < n + 15; i++) begin
      if (md) begin
        gbits[i] = s[lm1];
        s = {s[30:0], ^(s & tp & m)};
      end else begin
        gbits[i] = sv[lm1 - (i % (lm1 + 1))];
      end
    end
    for (int i = 0; i < n; i++) begin
      allz = 1'b1;
      for (int j = 1; j <= 14; j++) if (gbits[i+j]) allz = 1'b0;
      ebits[i] = gbits[i] | (zs & allz);
    end
  endtask

  task automatic start_load(input bit via_pin);
    @(negedge clk);
    if (via_pin) load_pin = 1'b1; else load_reg = 1'b1;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_bits(input int from, input int upto, input string tag);
    for (int i = from; i < upto; i++) begin
      chk(tx_data, ebits[i], (i == 0) ? "R2" : tag, i);
      @(negedge clk);
    end
  endtask

  task automatic drop_load();
    load_reg = 1'b0;
    load_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input bit md, input int lm1, input logic [31:0] tp,
                     input logic [31:0] sv, input bit zs, input int n,
                     input bit via_pin, input string tag);
    @(negedge clk);
    mode = md; len_m1 = lm1[4:0]; taps = tp; pat_set = sv; zs_en = zs;
    build(md, lm1, tp, sv, zs, n);
    start_load(via_pin);
    expect_bits(0, n, tag);
    drop_load();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pat_set = 32'hDEAD_BEEF; len_m1 = 5'd9; mode = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(tx_data, 1'b0, "R1", i);
      @(negedge clk);
    end

    // R5: every repeat length, alternating load source (R4)
    for (int l = 1; l <= 32; l++) begin
      run(1'b0, l - 1, 32'h0, 32'hB38F_1D64 ^ (32'h0101_0101 * l), 1'b0,
          2 * l + 20, l[0], (l[0]) ? "R4" : "R5");
    end

    // R3: held request, changed word does not reload
    @(negedge clk);
    mode = 1'b0; len_m1 = 5'd4; zs_en = 1'b0; pat_set = 32'h16;
    build(1'b0, 4, 32'h0, 32'h16, 1'b0, 100);
    start_load(1'b0);
    expect_bits(0, 30, "R3");
    pat_set = 32'h09;
    expect_bits(30, 90, "R3");
    drop_load();

    // R4: second source rising while the first is high does not reload
    @(negedge clk);
    pat_set = 32'h1B; len_m1 = 5'd6;
    build(1'b0, 6, 32'h0, 32'h1B, 1'b0, 100);
    start_load(1'b1);
    expect_bits(0, 20, "R4");
    load_reg = 1'b1; pat_set = 32'h40;
    expect_bits(20, 80, "R4");
    drop_load();

    // R6: several sequence lengths and tap sets
    run(1'b1, 3, 32'h0000_000C, 32'h9, 1'b0, 60, 1'b0, "R6");
    run(1'b1, 6, 32'h0000_0060, 32'h41, 1'b0, 200, 1'b1, "R6");
    run(1'b1, 19, 32'h0009_0000, 32'h0005_A3C7, 1'b0, 400, 1'b0, "R6");

    // R7: seed masked to zero becomes all ones
    run(1'b1, 19, 32'h0009_0000, 32'hFFF0_0000, 1'b0, 60, 1'b1, "R7");

    // R9 then R8: 19-zero run at the start, suppression off and on
    run(1'b1, 19, 32'h0009_0000, 32'h0008_0000, 1'b0, 60, 1'b0, "R9");
    run(1'b1, 19, 32'h0009_0000, 32'h0008_0000, 1'b1, 60, 1'b1, "R8");
    run(1'b1, 19, 32'h0009_0000, 32'h0005_A3C7, 1'b1, 400, 1'b0, "R8");
    run(1'b0, 31, 32'h0, 32'h0000_0001, 1'b1, 100, 1'b1, "R8");
    run(1'b0, 31, 32'h0, 32'h0000_0001, 1'b0, 100, 1'b0, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule